// File: doc/BRIEF.md
# Watchdog Timer with Reset-Cause Flags

This block is a 16-bit watchdog counter that counts upward at the system clock divided by 2 or by 128. Software stages a reload byte and a divider choice in a control register and then sends a validated service strobe. The strobe clears the low counter byte and loads the high byte from the staged reload byte, so that counting resumes from reload × 256. If software does not service the counter in time, it wraps from all-ones to zero. The block then raises a one-cycle watchdog reset request. The request waits while an external bus cycle is still running. It fires at once, with an abort indication, if that cycle is stuck waiting for a ready signal that did not arrive after its wait states.

The block also keeps a register of reset-cause flags. Each reset event writes a layered pattern into it that names the kind of reset. A hardware reset taken with the boot-mode input high leaves the watchdog stopped until a later reset that does not enter boot mode. Staged control writes never touch the running counter. They take effect at the next service or reset, and the input divider restarts at phase zero at that point.

Top module: `wdt_guard`

## Requirements
- R1: After `rst_n` is released, `count_o` is 0, `flags_o` is 0, and `wdt_req_o` and `bus_abort_o` are low. The divider select is ÷2.
- R2: With the divider set to ÷2, `count_o` rises by one every 2 clocks. The first increment comes at the 2nd clock edge after a service or reset.
- R3: With the divider set to ÷128, `count_o` rises by one every 128 clocks. The first increment comes at the 128th clock edge after a service or reset.
- R4: A service (`srv_i` high at an edge) sets `count_o` to {staged reload byte, 8'h00} and restarts the divider at phase zero.
- R5: A control write (`ctl_we_i`) changes only the staged reload byte and the staged divider select. The running count and the active divider change only at the next service or reset.
- R6: A wrap of the counter from 16'hFFFF to 16'h0000 enters the pending state. With the bus idle, `wdt_req_o` is then high for exactly one cycle. After that cycle, `flags_o` reads 5'b10001 and the counter is reloaded as in R4.
- R7: While `bus_busy_i` is high and `bus_late_i` is low, a pending request is held back and the counter keeps counting. The request is raised in the cycle the bus goes idle, with `bus_abort_o` low.
- R8: While pending with `bus_busy_i` and `bus_late_i` both high, `wdt_req_o` and `bus_abort_o` are high in the same cycle.
- R9: `rst_evt_i` with `rst_kind_i` sets `flags_o` exactly as follows. The bits are [4] watchdog, [3] power, [2] long hardware, [1] short hardware and [0] software. The codes are: 0 software gives 00001; 1 short hardware gives 00011; 2 long hardware gives 00111; 3 power-on gives 01111; 4 power-on after a partial supply dip gives 00111. Codes 5 to 7 are ignored.
- R10: A service clears only `flags_o[4]`.
- R11: A hardware reset (codes 1 to 4) with `boot_i` high stops the watchdog, and the count holds. A software reset (code 0) restarts counting whatever the value of `boot_i`.
- R12: When a service and a divider tick fall on the same edge, the service wins. The count becomes reload × 256 with no increment.
- R13: A reset event during the pending state cancels the request. `wdt_req_o` stays low, and the flags take the pattern for that event's kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous register reset, active low |
| ctl_we_i | input | 1 | Control write strobe |
| ctl_reload_i | input | 8 | Reload byte to stage |
| ctl_slow_i | input | 1 | Divider select to stage: 0 gives ÷2, 1 gives ÷128 |
| srv_i | input | 1 | Validated service strobe |
| rst_evt_i | input | 1 | Reset event strobe |
| rst_kind_i | input | 3 | Reset kind code (see R9) |
| boot_i | input | 1 | Boot mode selected at hardware reset |
| bus_busy_i | input | 1 | External bus cycle in progress |
| bus_late_i | input | 1 | Running bus cycle waits on a ready that did not come after its wait states |
| wdt_req_o | output | 1 | One-cycle watchdog reset request |
| bus_abort_o | output | 1 | The request aborts the running bus cycle |
| flags_o | output | 5 | Reset-cause flags |
| count_o | output | 16 | Current counter value |

## Verification
The service strobe and a divider tick can land on the same clock edge. The bench forces this by sending a second service exactly two clocks after a first one, at ÷2. It judges the outcome by reading `count_o` right after that edge, which must be reload × 256 and not one more, and by checking that the next increment comes two clocks later. A reset event can also coincide with a pending watchdog request. The bench holds the bus busy past the wrap and then applies a software reset. It checks that no request appears in that cycle and that the flags show only the software pattern.

// File: rtl/wdt_guard_pkg.sv
package wdt_guard_pkg;

    localparam int FLAG_W = 5;

    // flag bit positions
    localparam int FB_SOFT = 0;
    localparam int FB_HWS  = 1;
    localparam int FB_HWL  = 2;
    localparam int FB_PWR  = 3;
    localparam int FB_WDOG = 4;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_PEND = 2'd1,
        ST_OFF  = 2'd2
    } wd_state_e;

    typedef enum logic [2:0] {
        RK_SOFT      = 3'd0,
        RK_HW_SHORT  = 3'd1,
        RK_HW_LONG   = 3'd2,
        RK_POWER     = 3'd3,
        RK_POWER_DIP = 3'd4
    } rst_kind_e;

    localparam logic [FLAG_W-1:0] FLAGS_WDOG = FLAG_W'((1 << FB_WDOG) | (1 << FB_SOFT));

    function automatic logic kind_known(logic [2:0] code);
        return code <= 3'd4;
    endfunction

    function automatic logic kind_is_hw(logic [2:0] code);
        return (code != 3'd0) && (code <= 3'd4);
    endfunction

    function automatic logic [FLAG_W-1:0] flags_for(logic [2:0] code);
        logic [FLAG_W-1:0] f;
        f = '0;
        unique case (code)
            3'd0: f[FB_SOFT] = 1'b1;
            3'd1: begin f[FB_SOFT] = 1'b1; f[FB_HWS] = 1'b1; end
            3'd2, 3'd4: begin f[FB_SOFT] = 1'b1; f[FB_HWS] = 1'b1; f[FB_HWL] = 1'b1; end
            3'd3: begin f[FB_SOFT] = 1'b1; f[FB_HWS] = 1'b1; f[FB_HWL] = 1'b1; f[FB_PWR] = 1'b1; end
            default: f = '0;
        endcase
        return f;
    endfunction

endpackage

// File: rtl/wdt_prescale.sv
module wdt_prescale #(
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_i,
    input  logic run_i,
    input  logic slow_i,
    output logic tick_o
);
    localparam int W = (DIV_SLOW > 2) ? $clog2(DIV_SLOW) : 1;
    localparam logic [W-1:0] LIM_FAST = W'(DIV_FAST - 1);
    localparam logic [W-1:0] LIM_SLOW = W'(DIV_SLOW - 1);

    logic [W-1:0] phase;
    logic [W-1:0] limit;

    assign limit  = slow_i ? LIM_SLOW : LIM_FAST;
    assign tick_o = run_i && (phase == limit);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phase <= '0;
        end else if (clr_i) begin
            phase <= '0;
        end else if (run_i) begin
            phase <= tick_o ? '0 : phase + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_count.sv
module wdt_count #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    input  logic             inc_i,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    assign wrap_o = inc_i && (&count_o);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_o <= '0;
        end else if (load_i) begin
            count_o <= load_val_i;
        end else if (inc_i) begin
            count_o <= count_o + 1'b1;
        end
    end
endmodule

// File: rtl/wdt_cause.sv
module wdt_cause
    import wdt_guard_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_i,
    input  logic [FLAG_W-1:0] set_val_i,
    input  logic              clr_wdog_i,
    output logic [FLAG_W-1:0] flags_o
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flags_o <= '0;
        end else if (set_i) begin
            flags_o <= set_val_i;
        end else if (clr_wdog_i) begin
            flags_o[FB_WDOG] <= 1'b0;
        end
    end
endmodule

// File: rtl/wdt_guard.sv
module wdt_guard
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W    = 16,
    parameter int REL_W    = 8,
    parameter int DIV_FAST = 2,
    parameter int DIV_SLOW = 128
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctl_we_i,
    input  logic [REL_W-1:0] ctl_reload_i,
    input  logic             ctl_slow_i,
    input  logic             srv_i,
    input  logic             rst_evt_i,
    input  logic [2:0]       rst_kind_i,
    input  logic             boot_i,
    input  logic             bus_busy_i,
    input  logic             bus_late_i,
    output logic             wdt_req_o,
    output logic             bus_abort_o,
    output logic [4:0]       flags_o,
    output logic [CNT_W-1:0] count_o
);
    localparam int LOW_W = CNT_W - REL_W;

    wd_state_e state, state_nx;

    logic [REL_W-1:0] stg_reload;
    logic             stg_slow;
    logic             act_slow;

    logic rst_take, fire, svc, reload_evt, run, tick, inc, wrap;
    logic [FLAG_W-1:0] cause_val;

    assign rst_take   = rst_evt_i && kind_known(rst_kind_i);
    assign svc        = srv_i && !rst_take && !fire;
    assign reload_evt = rst_take || fire || svc;
    assign run        = (state != ST_OFF);
    assign inc        = tick && !reload_evt;
    assign cause_val  = rst_take ? flags_for(rst_kind_i) : FLAGS_WDOG;

    // staged and active control
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stg_reload <= '0;
            stg_slow   <= 1'b0;
            act_slow   <= 1'b0;
        end else begin
            if (ctl_we_i) begin
                stg_reload <= ctl_reload_i;
                stg_slow   <= ctl_slow_i;
            end
            if (reload_evt) begin
                act_slow <= stg_slow;
            end
        end
    end

    wdt_prescale #(.DIV_FAST(DIV_FAST), .DIV_SLOW(DIV_SLOW)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .clr_i  (reload_evt),
        .run_i  (run),
        .slow_i (act_slow),
        .tick_o (tick)
    );

    wdt_count #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (reload_evt),
        .load_val_i ({stg_reload, {LOW_W{1'b0}}}),
        .inc_i      (inc),
        .count_o    (count_o),
        .wrap_o     (wrap)
    );

    wdt_cause u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_i      (rst_take || fire),
        .set_val_i  (cause_val),
        .clr_wdog_i (svc),
        .flags_o    (flags_o)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_RUN;
        end else begin
            state <= state_nx;
        end
    end

    // next state
    always_comb begin
        state_nx = state;
        if (rst_take) begin
            state_nx = (kind_is_hw(rst_kind_i) && boot_i) ? ST_OFF : ST_RUN;
        end else if (fire) begin
            state_nx = ST_RUN;
        end else begin
            unique case (state)
                ST_RUN:  state_nx = wrap ? ST_PEND : ST_RUN;
                ST_PEND: state_nx = ST_PEND;
                ST_OFF:  state_nx = ST_OFF;
                default: state_nx = ST_RUN;
            endcase
        end
    end

    // outputs
    always_comb begin
        fire        = 1'b0;
        bus_abort_o = 1'b0;
        unique case (state)
            ST_PEND: begin
                fire        = !rst_take && (!bus_busy_i || bus_late_i);
                bus_abort_o = fire && bus_busy_i;
            end
            ST_RUN, ST_OFF: begin
                fire        = 1'b0;
                bus_abort_o = 1'b0;
            end
            default: begin
                fire        = 1'b0;
                bus_abort_o = 1'b0;
            end
        endcase
        wdt_req_o = fire;
    end
endmodule

// File: rtl/wdt_guard_chk.sv
module wdt_guard_chk
    import wdt_guard_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int REL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             srv_i,
    input logic             rst_evt_i,
    input logic [2:0]       rst_kind_i,
    input logic             bus_busy_i,
    input logic             bus_late_i,
    input logic             wdt_req_o,
    input logic             bus_abort_o,
    input logic [4:0]       flags_o,
    input logic [CNT_W-1:0] count_o,
    input logic [REL_W-1:0] stg_reload,
    input wd_state_e        state
);
    localparam int LOW_W = CNT_W - REL_W;

    p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |=> !wdt_req_o);

    p_wdog_flags_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |=> (flags_o == 5'b10001));

    p_hold_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_req_o |-> (!bus_busy_i || bus_late_i));

    p_abort_req_r8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_abort_o |-> (wdt_req_o && bus_busy_i));

    p_service_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_i && !rst_evt_i && !wdt_req_o) |=> (count_o == {$past(stg_reload), {LOW_W{1'b0}}}));

    p_service_clr_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (srv_i && !rst_evt_i && !wdt_req_o) |=> !flags_o[4]);

    p_power_flags_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && rst_kind_i == 3'd3) |=> (flags_o == 5'b01111));

    p_off_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OFF && !srv_i && !rst_evt_i) |=> $stable(count_o));

    p_cancel_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_evt_i && rst_kind_i <= 3'd4) |-> !wdt_req_o);
endmodule

bind wdt_guard wdt_guard_chk #(.CNT_W(CNT_W), .REL_W(REL_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .srv_i      (srv_i),
    .rst_evt_i  (rst_evt_i),
    .rst_kind_i (rst_kind_i),
    .bus_busy_i (bus_busy_i),
    .bus_late_i (bus_late_i),
    .wdt_req_o  (wdt_req_o),
    .bus_abort_o(bus_abort_o),
    .flags_o    (flags_o),
    .count_o    (count_o),
    .stg_reload (stg_reload),
    .state      (state)
);

// File: tb/wdt_guard_bench.sv
`timescale 1ns/1ps
module wdt_guard_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [7:0]  ctl_reload = '0;
    logic        ctl_slow = 1'b0;
    logic        srv = 1'b0;
    logic        rst_evt = 1'b0;
    logic [2:0]  rst_kind = '0;
    logic        boot = 1'b0;
    logic        busy = 1'b0;
    logic        late = 1'b0;
    logic        req, abort_o;
    logic [4:0]  flags;
    logic [15:0] count;

    int n_tests = 0;
    int n_fail  = 0;

    always #2.5 clk = ~clk;

    wdt_guard u_wdt_guard (
        .clk(clk), .rst_n(rst_n),
        .ctl_we_i(ctl_we), .ctl_reload_i(ctl_reload), .ctl_slow_i(ctl_slow),
        .srv_i(srv), .rst_evt_i(rst_evt), .rst_kind_i(rst_kind), .boot_i(boot),
        .bus_busy_i(busy), .bus_late_i(late),
        .wdt_req_o(req), .bus_abort_o(abort_o), .flags_o(flags), .count_o(count)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] rel, input logic slow);
        @(negedge clk);
        ctl_we = 1'b1; ctl_reload = rel; ctl_slow = slow;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic service();
        @(negedge clk);
        srv = 1'b1;
        @(negedge clk);
        srv = 1'b0;
    endtask

    task automatic reset_evt(input logic [2:0] k);
        @(negedge clk);
        rst_evt = 1'b1; rst_kind = k;
        @(negedge clk);
        rst_evt = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 count", count, 0);
        chk("R1 flags", flags, 0);
        chk("R1 req", req, 0);
        chk("R1 abort", abort_o, 0);
    endtask

    task automatic t_fast();
        write_ctl(8'h12, 1'b0);
        service();
        chk("R4 service load", count, 16'h1200);
        @(negedge clk);
        chk("R2 no early tick", count, 16'h1200);
        @(negedge clk);
        chk("R2 first tick", count, 16'h1201);
        repeat (2) @(negedge clk);
        chk("R2 second tick", count, 16'h1202);
    endtask

    task automatic t_slow();
        logic [15:0] c;
        write_ctl(8'h34, 1'b1);
        chk("R5 write leaves count", count[15:8], 8'h12);
        c = count;
        repeat (2) @(negedge clk);
        chk("R5 still fast", count, c + 16'd1);
        service();
        chk("R4 staged reload", count, 16'h3400);
        repeat (127) @(negedge clk);
        chk("R3 no tick before 128", count, 16'h3400);
        @(negedge clk);
        chk("R3 tick at 128", count, 16'h3401);
    endtask

    task automatic t_overflow();
        int first = 0;
        write_ctl(8'hFF, 1'b0);
        service();
        for (int i = 1; i <= 600; i++) begin
            @(negedge clk);
            if (req && first == 0) begin
                first = i;
                chk("R6 wrap value", count, 16'h0000);
                chk("R6 abort low", abort_o, 0);
                break;
            end
        end
        chk("R6 request delay", first, 512);
        @(negedge clk);
        chk("R6 request one cycle", req, 0);
        chk("R6 watchdog flags", flags, 5'b10001);
        chk("R6 reload after fire", count, 16'hFF00);
    endtask

    task automatic t_srv_clear();
        service();
        chk("R10 service clears watchdog flag", flags, 5'b00001);
    endtask

    task automatic t_bus_hold();
        int seen = 0;
        busy = 1'b1; late = 1'b0;
        service();
        for (int i = 1; i <= 520; i++) begin
            @(negedge clk);
            if (req) seen++;
        end
        chk("R7 held while busy", seen, 0);
        chk("R7 counter keeps running", count, 16'h0004);
        busy = 1'b0;
        #1;
        chk("R7 request on idle", req, 1);
        chk("R7 no abort", abort_o, 0);
        @(negedge clk);
        chk("R7 flags after fire", flags, 5'b10001);
    endtask

    task automatic t_bus_abort();
        int seen = 0;
        busy = 1'b1; late = 1'b0;
        service();
        chk("R10 clear before abort", flags, 5'b00001);
        for (int i = 1; i <= 513; i++) begin
            @(negedge clk);
            if (req) seen++;
        end
        chk("R8 held before late", seen, 0);
        late = 1'b1;
        #1;
        chk("R8 request", req, 1);
        chk("R8 abort", abort_o, 1);
        @(negedge clk);
        busy = 1'b0; late = 1'b0;
        chk("R8 flags after abort", flags, 5'b10001);
    endtask

    task automatic t_cancel();
        int seen = 0;
        busy = 1'b1;
        service();
        repeat (514) @(negedge clk);
        rst_evt = 1'b1; rst_kind = 3'd0;
        #1;
        chk("R13 request suppressed", req, 0);
        @(negedge clk);
        rst_evt = 1'b0;
        chk("R13 software flags", flags, 5'b00001);
        chk("R13 reload", count, 16'hFF00);
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (req) seen++;
        end
        chk("R13 no later request", seen, 0);
        busy = 1'b0;
    endtask

    task automatic t_flags();
        reset_evt(3'd1);
        chk("R9 short hw", flags, 5'b00011);
        reset_evt(3'd2);
        chk("R9 long hw", flags, 5'b00111);
        reset_evt(3'd0);
        chk("R9 software", flags, 5'b00001);
        reset_evt(3'd4);
        chk("R9 power dip", flags, 5'b00111);
        reset_evt(3'd3);
        chk("R9 power on", flags, 5'b01111);
        reset_evt(3'd6);
        chk("R9 unknown code ignored", flags, 5'b01111);
    endtask

    task automatic t_boot();
        logic [15:0] c;
        boot = 1'b1;
        reset_evt(3'd2);
        chk("R11 boot flags", flags, 5'b00111);
        c = count;
        repeat (300) @(negedge clk);
        chk("R11 count frozen", count, c);
        chk("R11 no request", req, 0);
        reset_evt(3'd0);
        c = count;
        repeat (2) @(negedge clk);
        chk("R11 software reset resumes", count, c + 16'd1);
        boot = 1'b0;
    endtask

    task automatic t_collide();
        write_ctl(8'h56, 1'b0);
        service();
        chk("R12 first load", count, 16'h5600);
        service();
        chk("R12 service beats tick", count, 16'h5600);
        repeat (2) @(negedge clk);
        chk("R12 tick after collision", count, 16'h5601);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_fast();
        t_slow();
        t_overflow();
        t_srv_clear();
        t_bus_hold();
        t_bus_abort();
        t_cancel();
        t_flags();
        t_boot();
        t_collide();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog timeout actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule